// File: doc/BRIEF.md
# Packed Byte Variable Arithmetic Shifter

This execution unit takes a 32-bit source word and treats it as four signed byte lanes. It shifts every lane right arithmetically by one common amount, and that amount comes from a second register operand. One flag in the instruction word chooses between two forms. The truncating form simply discards the shifted-out bits. The rounding form adds one half of the result's least significant bit before the bits are discarded. Each lane writes its result back to the byte position it came from.

The unit also decodes the 32-bit instruction word. A word that does not carry the expected opcode fields raises a reserved-instruction fault. A matching word issued while the vector resources are switched off raises a disabled fault. A legal request produces a registered result, a write enable and the destination register index one clock after it is accepted.

Top module: `packed_sar_unit`

## Requirements
- R1: The source splits into four 8-bit lanes (bits 31..24, 23..16, 15..8, 7..0). Each lane is processed on its own and its result lands in the same byte position of `wr_data`.
- R2: The shift amount is `amt_val[2:0]`, read as an unsigned value from 0 to 7. Bits 31..3 of `amt_val` have no effect on the result.
- R3: In the truncating form (flag bit 0), each lane becomes floor(lane / 2^amount). The vacated upper bits are filled with copies of the lane's sign bit.
- R4: In the rounding form (flag bit 1), each lane becomes floor((lane + 2^(amount-1)) / 2^amount). The result is computed in a 9-bit per-lane intermediate, so no carry ever crosses into a neighbouring lane.
- R5: An amount of 0 returns every lane unchanged in both forms, with no rounding increment.
- R6: A word is accepted only when bits 31..26 = 001000, bits 9..3 = 0111001 and bits 2..0 = 101. Bit 10 is the rounding flag, and bits 15..11 hold the destination index that appears on `wr_idx`.
- R7: A request with a matching word while `dsp_enable` is 0 asserts `flt_disabled` for one cycle. It does not assert `wr_en`, and it leaves `wr_data` unchanged.
- R8: A request with a non-matching word asserts `flt_reserved` for one cycle, whatever the state of `dsp_enable`. It does not assert `wr_en`, and it leaves `wr_data` unchanged.
- R9: A legal request presents `wr_en`, `wr_idx` and `wr_data` on the clock edge after `req_valid` is sampled high. The enable and fault outputs are pulses lasting one cycle.
- R10: A synchronous active-high `rst` clears `wr_en`, `wr_idx`, `wr_data`, `flt_reserved` and `flt_disabled` to zero.
- R11: A cycle without `req_valid` produces no write and no fault, and leaves `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| instr_word | input | 32 | Instruction word to decode |
| dsp_enable | input | 1 | Vector resources are switched on |
| src_val | input | 32 | Four packed signed bytes to shift |
| amt_val | input | 32 | Shift amount operand (only bits 2..0 are used) |
| wr_en | output | 1 | Registered write enable |
| wr_idx | output | 5 | Registered destination register index |
| wr_data | output | 32 | Registered packed result |
| flt_reserved | output | 1 | Reserved-instruction fault pulse |
| flt_disabled | output | 1 | Resources-disabled fault pulse |

## Verification
The bench sweeps every byte value against every shift amount in both forms. This catches a logical shift, which would fill negative lanes with zeros, and a rounding path that forgets the shift-by-zero bypass, which would corrupt odd values at amount 0. Lanes of 0x7F and 0xFF are rounded together to expose any carry that leaks across a byte boundary. Upper garbage in the amount operand would change the result if the decoder used more than three bits. Words that differ from a legal word in a single opcode field must fault without writing, and a design that decoded too loosely would write instead. A disabled request must also fault, and a design that checked the enable flag before the opcode would report the wrong fault for a bad word.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int INSTR_W   = 32;
  localparam int IDX_W     = 5;

  // field positions of the instruction word (behavioural: decoded below)
  localparam int MAJ_HI    = 31;
  localparam int MAJ_LO    = 26;
  localparam int DST_HI    = 15;
  localparam int DST_LO    = 11;
  localparam int RND_BIT   = 10;
  localparam int MIN_HI    = 9;
  localparam int MIN_LO    = 3;
  localparam int SUF_HI    = 2;
  localparam int SUF_LO    = 0;

  localparam logic [MAJ_HI-MAJ_LO:0] MAJ_CODE = 6'b001000;
  localparam logic [MIN_HI-MIN_LO:0] MIN_CODE = 7'b0111001;
  localparam logic [SUF_HI-SUF_LO:0] SUF_CODE = 3'b101;

  typedef enum logic [1:0] {
    OUT_NONE     = 2'd0,
    OUT_WRITE    = 2'd1,
    OUT_RESERVED = 2'd2,
    OUT_DISABLED = 2'd3
  } outcome_e;

  typedef struct packed {
    logic             hit;
    logic             rnd;
    logic [IDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
  import pbs_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output dec_t               dec
);
  logic maj_ok, min_ok, suf_ok;

  always_comb begin
    maj_ok  = (word[MAJ_HI:MAJ_LO] == MAJ_CODE);
    min_ok  = (word[MIN_HI:MIN_LO] == MIN_CODE);
    suf_ok  = (word[SUF_HI:SUF_LO] == SUF_CODE);
    dec.hit = maj_ok && min_ok && suf_ok;
    dec.rnd = word[RND_BIT];
    dec.dst = word[DST_HI:DST_LO];
  end
endmodule

// File: rtl/pbs_lane.sv
module pbs_lane #(
  parameter int LANE_W = 8,
  localparam int SH_W  = $clog2(LANE_W),
  localparam int EXT_W = LANE_W + 1
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [SH_W-1:0]   sa,
  input  logic              rnd,
  output logic [LANE_W-1:0] lane_out
);
  logic signed [LANE_W-1:0] x_s;
  logic signed [LANE_W-1:0] trunc_v;
  logic signed [EXT_W-1:0]  dbl_v;
  logic signed [EXT_W-1:0]  dbl_sh;
  logic signed [EXT_W-1:0]  rnd_sum;

  always_comb begin
    x_s      = $signed(lane_in);
    trunc_v  = x_s >>> sa;
    // doubled lane keeps the most significant discarded bit in bit 0
    dbl_v    = $signed({lane_in, 1'b0});
    dbl_sh   = dbl_v >>> sa;
    rnd_sum  = dbl_sh + EXT_W'(1);
    if (sa == '0)
      lane_out = lane_in;
    else if (rnd)
      lane_out = rnd_sum[EXT_W-1:1];
    else
      lane_out = trunc_v;
  end

  always_comb begin
    if (sa == '0)
      AST_ZERO_PASS: assert (lane_out == lane_in); // R5
    if (!rnd && sa != '0)
      AST_SIGN_KEPT: assert (lane_out[LANE_W-1] == lane_in[LANE_W-1]); // R3
  end
endmodule

// File: rtl/pbs_lane_array.sv
module pbs_lane_array #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int SH_W   = $clog2(LANE_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [SH_W-1:0]   sa,
  input  logic              rnd,
  output logic [DATA_W-1:0] res
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbs_lane #(.LANE_W(LANE_W)) u_lane (
      .lane_in (src[g*LANE_W +: LANE_W]),
      .sa      (sa),
      .rnd     (rnd),
      .lane_out(res[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/packed_sar_unit.sv
module packed_sar_unit
  import pbs_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int SH_W   = $clog2(LANE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [INSTR_W-1:0]  instr_word,
  input  logic                dsp_enable,
  input  logic [DATA_W-1:0]   src_val,
  input  logic [DATA_W-1:0]   amt_val,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [DATA_W-1:0]   wr_data,
  output logic                flt_reserved,
  output logic                flt_disabled
);
  dec_t            dec;
  logic [SH_W-1:0] sa;
  logic [DATA_W-1:0] lane_res;
  outcome_e        outcome;

  pbs_decode u_dec (
    .word(instr_word),
    .dec (dec)
  );

  assign sa = amt_val[SH_W-1:0];

  pbs_lane_array #(.LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .src(src_val),
    .sa (sa),
    .rnd(dec.rnd),
    .res(lane_res)
  );

  // the opcode check comes first, so a bad word is reserved even when disabled
  always_comb begin
    if (!req_valid)       outcome = OUT_NONE;
    else if (!dec.hit)    outcome = OUT_RESERVED;
    else if (!dsp_enable) outcome = OUT_DISABLED;
    else                  outcome = OUT_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en        <= 1'b0;
      wr_idx       <= '0;
      wr_data      <= '0;
      flt_reserved <= 1'b0;
      flt_disabled <= 1'b0;
    end else begin
      wr_en        <= (outcome == OUT_WRITE);
      flt_reserved <= (outcome == OUT_RESERVED);
      flt_disabled <= (outcome == OUT_DISABLED);
      if (outcome == OUT_WRITE) begin
        wr_idx  <= dec.dst;
        wr_data <= lane_res;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, flt_reserved, flt_disabled})); // R7
  AST_WRITE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(req_valid && dsp_enable)); // R9
  AST_RESERVED_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    flt_reserved |-> $past(req_valid)); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> $stable(wr_data)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !(wr_en || flt_reserved || flt_disabled)); // R11
endmodule

// File: tb/sim_packed_sar_unit.sv
module sim_packed_sar_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] instr_word;
  logic        dsp_enable;
  logic [31:0] src_val;
  logic [31:0] amt_val;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        flt_reserved;
  logic        flt_disabled;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  packed_sar_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .instr_word(instr_word),
    .dsp_enable(dsp_enable), .src_val(src_val), .amt_val(amt_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flt_reserved(flt_reserved), .flt_disabled(flt_disabled)
  );

  function automatic logic [31:0] mk(input logic rnd, input logic [4:0] rd);
    return {6'b001000, 5'd3, 5'd4, rd, rnd, 7'b0111001, 3'b101};
  endfunction

  function automatic logic [7:0] ref_lane(input logic [7:0] x, input int sa, input logic rnd);
    int v;
    v = $signed(x);
    if (sa == 0) return x;
    if (!rnd) return 8'(v >>> sa);
    return 8'((v + (1 << (sa - 1))) >>> sa);
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] s, input int sa, input logic rnd);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = ref_lane(s[i*8 +: 8], sa, rnd);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, outputs register at the next rising edge, sample at the falling edge after
  task automatic issue(input logic [31:0] w, input logic en, input logic [31:0] s, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; instr_word = w; dsp_enable = en; src_val = s; amt_val = a;
    @(negedge clk);
    req_valid = 1'b0; instr_word = 32'h0; src_val = 32'hDEAD_BEEF; amt_val = 32'h0;
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; instr_word = '0; dsp_enable = 1'b1;
    src_val = '0; amt_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset", {wr_en, flt_reserved, flt_disabled, wr_idx, wr_data}, '0);
  endtask

  task automatic t_sweep;
    for (int rnd = 0; rnd < 2; rnd++)
      for (int sa = 0; sa < 8; sa++)
        for (int x = 0; x < 256; x += 4) begin
          logic [31:0] s;
          s = {8'(x), 8'(x + 1), 8'(x + 2), 8'(x + 3)};
          issue(mk(rnd[0], 5'd9), 1'b1, s, 32'(sa));
          if (rnd == 0) check("R3 trunc", wr_data, ref_word(s, sa, 1'b0));
          else          check("R4 round", wr_data, ref_word(s, sa, 1'b1));
        end
  endtask

  task automatic t_zero;
    issue(mk(1'b1, 5'd1), 1'b1, 32'h7F81_0103, 32'h0);
    check("R5 zero round", wr_data, 32'h7F81_0103);
    issue(mk(1'b0, 5'd1), 1'b1, 32'hFF80_5501, 32'hFFFF_FFF8);
    check("R5 zero trunc", wr_data, 32'hFF80_5501);
  endtask

  task automatic t_lanes;
    issue(mk(1'b1, 5'd2), 1'b1, 32'h7FFF_7FFF, 32'h1);
    check("R1 R4 no carry", wr_data, 32'h4000_4000);
    issue(mk(1'b0, 5'd2), 1'b1, 32'h80_7F_01_FE, 32'h7);
    check("R1 lanes", wr_data, 32'hFF_00_00_FF);
  endtask

  task automatic t_amt_upper;
    issue(mk(1'b0, 5'd2), 1'b1, 32'h8040_2010, 32'hABCD_EF02);
    check("R2 upper ignored", wr_data, ref_word(32'h8040_2010, 2, 1'b0));
  endtask

  task automatic t_timing;
    @(negedge clk);
    req_valid = 1'b1; instr_word = mk(1'b0, 5'd17); dsp_enable = 1'b1;
    src_val = 32'h4040_4040; amt_val = 32'h1;
    #1 check("R9 not before edge", {31'b0, wr_en}, 64'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 enable", {31'b0, wr_en}, 64'h1);
    check("R6 R9 index", {59'b0, wr_idx}, 64'd17);
    check("R9 data", wr_data, 32'h2020_2020);
    @(negedge clk);
    check("R9 pulse", {31'b0, wr_en}, 64'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] keep;
    keep = wr_data;
    issue(mk(1'b1, 5'd5), 1'b0, 32'h1111_1111, 32'h1);
    check("R7 fault", {wr_en, flt_reserved, flt_disabled}, 3'b001);
    check("R7 data held", wr_data, keep);
  endtask

  task automatic t_reserved;
    logic [31:0] bad [4];
    logic [31:0] keep;
    bad[0] = mk(1'b0, 5'd5) ^ 32'h0400_0000; // major field
    bad[1] = mk(1'b0, 5'd5) ^ 32'h0000_0100; // minor field
    bad[2] = mk(1'b0, 5'd5) ^ 32'h0000_0002; // suffix field
    bad[3] = 32'h0;
    for (int i = 0; i < 4; i++) begin
      keep = wr_data;
      issue(bad[i], i[0], 32'h5555_5555, 32'h1);
      check("R6 R8 fault", {wr_en, flt_reserved, flt_disabled}, 3'b010);
      check("R8 data held", wr_data, keep);
    end
  endtask

  task automatic t_idle;
    logic [31:0] keep;
    keep = wr_data;
    @(negedge clk);
    instr_word = mk(1'b0, 5'd6); src_val = 32'h1234_5678; dsp_enable = 1'b1;
    @(negedge clk);
    check("R11 idle", {wr_en, flt_reserved, flt_disabled}, 3'b000);
    check("R11 data held", wr_data, keep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_lanes();
    t_amt_upper();
    t_timing();
    t_sweep();
    t_disabled();
    t_reserved();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule